// File: doc/BRIEF.md
# Chained Page-Splitting DMA Engine

This block is a single-channel DMA engine. It takes bytes from a peripheral byte stream and writes them into memory on its own, so the processor does not have to move each byte. Software uses a small register bus to fill a table of up to four address/count segments. It then writes a start bit and can go on with other work. The engine makes every memory address itself. Each accepted byte goes to the current address. After each byte the address goes up by one and the remaining count goes down by one.

A physical buffer may be scattered across pages. For that reason the engine walks the segment table in order, moving to the next entry when the current one runs out. A segment with a count of zero, or the last table slot, ends the chain. Bursts toward memory are flagged with first and last markers. A burst is always closed on the last byte of a page, so no burst spans two pages. One interrupt goes up when the whole chain is complete or when an error stops the engine. The interrupt stays up until software clears it.

Top module: `chain_dma`

## Requirements
- R1: Register offset 1 holds the segment selector. Offsets 2 and 3 write and read the address and the byte count of the selected table entry. Writes to offsets 2 and 3 while the engine is busy are ignored.
- R2: Writing offset 0 with bit 0 set while idle starts segment 0, and the engine goes busy. Status read at offset 0 has busy in bit 0, done in bit 1, error in bit 2 and the current segment index in bits 5:4. A start write while busy is ignored.
- R3: A byte is accepted when devValid and devReady are both high. In that same cycle memWrEn is high, memAddr equals the current address and memWrData equals devData. After the byte, the current address (offset 4) has gone up by one and the remaining count (offset 5) has gone down by one.
- R4: memBurstLast is high on a byte whose address has all page-offset bits set (page size 4096 by default) and on the final byte of a segment. memBurstFirst is high on the first byte after a start, after a segment change, and after a page end.
- R5: A byte that continues a burst never sits at offset 0 of a page.
- R6: When a segment's count runs out, the next entry is loaded in the same cycle. The next byte then goes to that entry's address. A following entry with a zero count ends the chain, and so does reaching index 3.
- R7: After the final byte of the chain, busy drops, done is set and irq goes high.
- R8: devErr while busy stops the engine at once. The byte offered in that cycle is not written. Error and irq are set, and the current address and count stay frozen.
- R9: A start whose segment 0 count is zero sets error and irq, does not go busy and writes nothing.
- R10: irq stays high until software writes offset 0 with bit 1 set. That write clears irq, done and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| devValid | input | 1 | Device offers a byte |
| devData | input | 8 | Device byte |
| devErr | input | 1 | Device error |
| devReady | output | 1 | Engine accepts a byte |
| memWrEn | output | 1 | Memory byte write |
| memAddr | output | 32 | Memory byte address |
| memWrData | output | 8 | Memory write data |
| memBurstFirst | output | 1 | First byte of a burst |
| memBurstLast | output | 1 | Last byte of a burst |
| irq | output | 1 | Interrupt request |

## Verification
The main chain test starts three bytes below a page end. It then crosses into the next page and moves to a second segment at a far address. A design that ran a burst through the page edge would miss memBurstLast at 0x1FFF. A design that lost a cycle at the segment change would write to 0x2002 or stall. A four-segment chain of single bytes checks that the walk stops at the last slot and does not wrap back to slot 0. The error test raises devErr together with a valid byte. A design that let that byte through, or kept stepping, would show a moved address or a write strobe. Start and table writes made in the middle of a transfer, a zero-count start, and an interrupt held across idle cycles each catch a control path that reacts when it should not.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } pathCmd_t;

  typedef enum logic {ST_IDLE, ST_RUN} runState_t;

  localparam logic [3:0] REG_CTRL  = 4'd0;
  localparam logic [3:0] REG_SEL   = 4'd1;
  localparam logic [3:0] REG_SADDR = 4'd2;
  localparam logic [3:0] REG_SCNT  = 4'd3;
  localparam logic [3:0] REG_CADDR = 4'd4;
  localparam logic [3:0] REG_CCNT  = 4'd5;
endpackage

// File: rtl/chain_dma_path.sv
module chain_dma_path
  import chain_dma_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int CntW      = 16,
  parameter int NumSegs   = 4,
  parameter int PageBytes = 4096,
  parameter int DataW     = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pathCmd_t                   cmd,
  input  logic [$clog2(NumSegs)-1:0] loadIdx,
  input  logic [$clog2(NumSegs)-1:0] probeIdx,
  input  logic                       selWr,
  input  logic                       tabAddrWr,
  input  logic                       tabCntWr,
  input  logic [DataW-1:0]           wrData,
  output logic [AddrW-1:0]           curAddr,
  output logic [CntW-1:0]            curCnt,
  output logic [AddrW-1:0]           selAddr,
  output logic [CntW-1:0]            selCnt,
  output logic [$clog2(NumSegs)-1:0] segSel,
  output logic                       probeZero,
  output logic                       lastBeat,
  output logic                       pageEnd,
  output logic                       burstOpen
);
  localparam int SegW  = $clog2(NumSegs);
  localparam int PageW = $clog2(PageBytes);

  logic [AddrW-1:0] tabAddr [NumSegs];
  logic [CntW-1:0]  tabCnt  [NumSegs];

  for (genvar i = 0; i < NumSegs; i++) begin : g_seg
    logic [AddrW-1:0] addrQ;
    logic [CntW-1:0]  cntQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrQ <= '0;
        cntQ  <= '0;
      end else if (segSel == SegW'(i)) begin
        if (tabAddrWr) addrQ <= wrData[AddrW-1:0];
        if (tabCntWr)  cntQ  <= wrData[CntW-1:0];
      end
    end
    assign tabAddr[i] = addrQ;
    assign tabCnt[i]  = cntQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) segSel <= '0;
    else if (selWr) segSel <= wrData[SegW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      curCnt    <= '0;
      burstOpen <= 1'b0;
    end else if (cmd.load) begin
      curAddr   <= tabAddr[loadIdx];
      curCnt    <= tabCnt[loadIdx];
      burstOpen <= 1'b0;
    end else if (cmd.step) begin
      curAddr   <= curAddr + 1'b1;
      curCnt    <= curCnt - 1'b1;
      burstOpen <= !(lastBeat || pageEnd);
    end
  end

  assign selAddr   = tabAddr[segSel];
  assign selCnt    = tabCnt[segSel];
  assign probeZero = (tabCnt[probeIdx] == '0);
  assign lastBeat  = (curCnt == CntW'(1));
  assign pageEnd   = &curAddr[PageW-1:0];

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.step && !cmd.load) |=> (curAddr == $past(curAddr) + 1'b1) && (curCnt == $past(curCnt) - 1'b1)); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.step || cmd.load) |=> $stable(curAddr) && $stable(curCnt)); // R8
endmodule

// File: rtl/chain_dma_ctrl.sv
module chain_dma_ctrl
  import chain_dma_pkg::*;
#(
  parameter int NumSegs = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctrlWr,
  input  logic                       wrStart,
  input  logic                       wrClear,
  input  logic                       devValid,
  input  logic                       devErr,
  input  logic                       probeZero,
  input  logic                       lastBeat,
  output pathCmd_t                   cmd,
  output logic [$clog2(NumSegs)-1:0] loadIdx,
  output logic [$clog2(NumSegs)-1:0] probeIdx,
  output logic [$clog2(NumSegs)-1:0] curSeg,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic                       irq,
  output logic                       devReady,
  output logic                       beat
);
  localparam int SegW = $clog2(NumSegs);
  localparam logic [SegW-1:0] LastSeg = SegW'(NumSegs - 1);

  runState_t state;
  logic startNow, errNow, chainEnd;

  assign busy     = (state == ST_RUN);
  assign startNow = ctrlWr && wrStart && !busy;
  assign errNow   = busy && devErr;
  assign devReady = busy && !devErr;
  assign beat     = devReady && devValid;
  assign probeIdx = busy ? curSeg + 1'b1 : '0;
  assign chainEnd = (curSeg == LastSeg) || probeZero;
  assign loadIdx  = startNow ? '0 : curSeg + 1'b1;

  always_comb begin
    cmd      = '0;
    cmd.step = beat;
    cmd.load = (startNow && !probeZero) || (beat && lastBeat && !chainEnd);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      curSeg <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (ctrlWr && wrClear) begin
        done <= 1'b0;
        err  <= 1'b0;
        irq  <= 1'b0;
      end
      if (startNow) begin
        done <= 1'b0;
        if (probeZero) begin
          err <= 1'b1;
          irq <= 1'b1;
        end else begin
          err    <= 1'b0;
          irq    <= 1'b0;
          state  <= ST_RUN;
          curSeg <= '0;
        end
      end else if (errNow) begin
        err   <= 1'b1;
        irq   <= 1'b1;
        state <= ST_IDLE;
      end else if (beat && lastBeat) begin
        if (chainEnd) begin
          done  <= 1'b1;
          irq   <= 1'b1;
          state <= ST_IDLE;
        end else begin
          curSeg <= curSeg + 1'b1;
        end
      end
    end
  end

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(ctrlWr && (wrClear || wrStart))) |=> irq); // R10
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err)); // R7
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    errNow |=> (!busy && err && irq)); // R8
  AST_ZERO_START: assert property (@(posedge clk) disable iff (!rstN)
    (startNow && probeZero) |=> (!busy && err)); // R9
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int CntW      = 16,
  parameter int NumSegs   = 4,
  parameter int PageBytes = 4096
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic             devValid,
  input  logic [7:0]       devData,
  input  logic             devErr,
  output logic             devReady,
  output logic             memWrEn,
  output logic [AddrW-1:0] memAddr,
  output logic [7:0]       memWrData,
  output logic             memBurstFirst,
  output logic             memBurstLast,
  output logic             irq
);
  localparam int SegW  = $clog2(NumSegs);
  localparam int PageW = $clog2(PageBytes);

  pathCmd_t         cmd;
  logic [SegW-1:0]  loadIdx, probeIdx, curSeg, segSel;
  logic             busy, done, err, beat;
  logic             probeZero, lastBeat, pageEnd, burstOpen;
  logic [AddrW-1:0] curAddr, selAddr;
  logic [CntW-1:0]  curCnt, selCnt;
  logic             ctrlWr;

  assign ctrlWr = regWrEn && (regAddr == REG_CTRL);

  chain_dma_ctrl #(.NumSegs(NumSegs)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .ctrlWr(ctrlWr), .wrStart(regWrData[0]), .wrClear(regWrData[1]),
    .devValid(devValid), .devErr(devErr),
    .probeZero(probeZero), .lastBeat(lastBeat),
    .cmd(cmd), .loadIdx(loadIdx), .probeIdx(probeIdx), .curSeg(curSeg),
    .busy(busy), .done(done), .err(err), .irq(irq),
    .devReady(devReady), .beat(beat)
  );

  chain_dma_path #(
    .AddrW(AddrW), .CntW(CntW), .NumSegs(NumSegs),
    .PageBytes(PageBytes), .DataW(32)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .cmd(cmd), .loadIdx(loadIdx), .probeIdx(probeIdx),
    .selWr(regWrEn && (regAddr == REG_SEL)),
    .tabAddrWr(regWrEn && !busy && (regAddr == REG_SADDR)),
    .tabCntWr(regWrEn && !busy && (regAddr == REG_SCNT)),
    .wrData(regWrData),
    .curAddr(curAddr), .curCnt(curCnt),
    .selAddr(selAddr), .selCnt(selCnt), .segSel(segSel),
    .probeZero(probeZero), .lastBeat(lastBeat),
    .pageEnd(pageEnd), .burstOpen(burstOpen)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[0] = busy;
        regRdData[1] = done;
        regRdData[2] = err;
        regRdData[4 +: SegW] = curSeg;
      end
      REG_SEL:   regRdData[SegW-1:0]  = segSel;
      REG_SADDR: regRdData[AddrW-1:0] = selAddr;
      REG_SCNT:  regRdData[CntW-1:0]  = selCnt;
      REG_CADDR: regRdData[AddrW-1:0] = curAddr;
      REG_CCNT:  regRdData[CntW-1:0]  = curCnt;
      default:   regRdData = '0;
    endcase
  end

  assign memWrEn       = beat;
  assign memAddr       = curAddr;
  assign memWrData     = devData;
  assign memBurstFirst = beat && !burstOpen;
  assign memBurstLast  = beat && (lastBeat || pageEnd);

  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !memBurstFirst) |-> (memAddr[PageW-1:0] != '0)); // R5
  AST_WRITE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (devReady && devValid)); // R3
endmodule

// File: tb/chain_dma_test.sv
`timescale 1ns/1ps
module chain_dma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        devValid = 1'b0;
  logic [7:0]  devData = '0;
  logic        devErr = 1'b0;
  logic        devReady, memWrEn, memBurstFirst, memBurstLast, irq;
  logic [31:0] memAddr;
  logic [7:0]  memWrData;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  chain_dma uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .devValid(devValid), .devData(devData), .devErr(devErr), .devReady(devReady),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .memBurstFirst(memBurstFirst), .memBurstLast(memBurstLast), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setSeg(input int idx, input logic [31:0] a, input logic [31:0] c);
    regWrite(4'd1, idx);
    regWrite(4'd2, a);
    regWrite(4'd3, c);
  endtask

  task automatic sendByte(input string tag, input logic [7:0] d, input logic [31:0] expAddr,
                          input logic expFirst, input logic expLast);
    @(negedge clk);
    devValid = 1'b1; devData = d;
    #1;
    chk({tag, " R3 memWrEn"}, memWrEn, 1);
    chk({tag, " R3 memAddr"}, memAddr, expAddr);
    chk({tag, " R3 memWrData"}, memWrData, d);
    chk({tag, " R4 first"}, memBurstFirst, expFirst);
    chk({tag, " R4 last"}, memBurstLast, expLast);
    @(negedge clk);
    devValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(4'd0, v);
    chk("R2 reset status", v, 0);
    chk("R10 reset irq", irq, 0);
    chk("R2 reset ready", devReady, 0);
  endtask

  task automatic testTable();
    logic [31:0] v;
    setSeg(0, 32'h0000_1FFD, 5);
    setSeg(1, 32'h0000_8000, 2);
    regWrite(4'd1, 0);
    regRead(4'd2, v); chk("R1 seg0 addr", v, 32'h1FFD);
    regRead(4'd3, v); chk("R1 seg0 count", v, 5);
    regWrite(4'd1, 1);
    regRead(4'd2, v); chk("R1 seg1 addr", v, 32'h8000);
    regWrite(4'd1, 0);
  endtask

  task automatic testChain();
    logic [31:0] v;
    regWrite(4'd0, 1);
    regRead(4'd0, v); chk("R2 busy after start", v[2:0], 3'b001);
    chk("R2 ready", devReady, 1);
    sendByte("b0", 8'hA0, 32'h1FFD, 1, 0);
    regRead(4'd4, v); chk("R3 cur addr", v, 32'h1FFE);
    regRead(4'd5, v); chk("R3 cur count", v, 4);
    sendByte("b1", 8'hA1, 32'h1FFE, 0, 0);
    regWrite(4'd3, 99);
    regRead(4'd3, v); chk("R1 table write while busy ignored", v, 5);
    regWrite(4'd0, 1);
    regRead(4'd4, v); chk("R2 start while busy ignored", v, 32'h1FFF);
    sendByte("b2 R5", 8'hA2, 32'h1FFF, 0, 1);
    sendByte("b3 R5", 8'hA3, 32'h2000, 1, 0);
    sendByte("b4 R6", 8'hA4, 32'h2001, 0, 1);
    regRead(4'd0, v); chk("R6 seg index 1", v[5:0], 6'h11);
    sendByte("b5 R6", 8'hA5, 32'h8000, 1, 0);
    sendByte("b6 R6", 8'hA6, 32'h8001, 0, 1);
    regRead(4'd0, v); chk("R7 done status", v[2:0], 3'b010);
    chk("R7 irq", irq, 1);
    chk("R7 ready low", devReady, 0);
  endtask

  task automatic testIrqClear();
    logic [31:0] v;
    repeat (4) @(negedge clk);
    chk("R10 irq held", irq, 1);
    regWrite(4'd0, 2);
    chk("R10 irq cleared", irq, 0);
    regRead(4'd0, v); chk("R10 status cleared", v[2:0], 3'b000);
  endtask

  task automatic testFourSegs();
    logic [31:0] v;
    setSeg(0, 32'h40, 1);
    setSeg(1, 32'h50, 1);
    setSeg(2, 32'h60, 1);
    setSeg(3, 32'h70, 1);
    regWrite(4'd0, 1);
    sendByte("s0 R6", 8'h10, 32'h40, 1, 1);
    sendByte("s1 R6", 8'h11, 32'h50, 1, 1);
    sendByte("s2 R6", 8'h12, 32'h60, 1, 1);
    sendByte("s3 R6", 8'h13, 32'h70, 1, 1);
    regRead(4'd0, v); chk("R6 ends at last slot", v[5:0], 6'h32);
    chk("R7 irq four segs", irq, 1);
    regWrite(4'd0, 2);
  endtask

  task automatic testError();
    logic [31:0] v;
    setSeg(0, 32'h100, 10);
    regWrite(4'd0, 1);
    sendByte("e0", 8'h01, 32'h100, 1, 0);
    sendByte("e1", 8'h02, 32'h101, 0, 0);
    @(negedge clk);
    devValid = 1'b1; devErr = 1'b1; devData = 8'hEE;
    #1 chk("R8 no write on error", memWrEn, 0);
    @(negedge clk);
    devValid = 1'b0; devErr = 1'b0;
    regRead(4'd0, v); chk("R8 error status", v[2:0], 3'b100);
    chk("R8 irq", irq, 1);
    repeat (3) @(negedge clk);
    regRead(4'd4, v); chk("R8 addr frozen", v, 32'h102);
    regRead(4'd5, v); chk("R8 count frozen", v, 8);
    regWrite(4'd0, 2);
  endtask

  task automatic testZeroStart();
    logic [31:0] v;
    logic sawWrite;
    setSeg(0, 32'h300, 0);
    sawWrite = 1'b0;
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 4'd0; regWrData = 1; devValid = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    #1 sawWrite = memWrEn;
    @(negedge clk);
    devValid = 1'b0;
    chk("R9 no write", sawWrite, 0);
    regRead(4'd0, v); chk("R9 error not busy", v[2:0], 3'b100);
    chk("R9 irq", irq, 1);
    regRead(4'd4, v); chk("R9 addr untouched", v, 32'h102);
    regWrite(4'd0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTable();
    testChain();
    testIrqClear();
    testFourSegs();
    testError();
    testZeroStart();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule